// File: doc/BRIEF.md
# Three-Multiplier NTT Butterfly Datapath

This block is the arithmetic core of a number theoretic transform engine. Each cycle it may accept a pair of coefficients, a twiddle (or scale) value, a modulus and a two-bit operation code. After a fixed number of cycles it returns two reduced coefficients with a valid strobe. Address generation, coefficient and twiddle memories and the transform-level sequencing belong to the surrounding engine.

Each operation has its own modular multiplier. In the forward butterfly the multiplier sits ahead of the modular add/subtract. In the inverse butterfly it sits behind them. A third multiplier scales lane a by the inverse of the transform length. A fourth code passes both lanes through untouched. The modulus travels with the operands, so every transfer may use a different one of up to 64 bits. All four paths are aligned to one latency, so the operation code can change on every cycle. Operands are expected to be already reduced below the modulus, and the modulus must be at least 2.

Top module: `ntt_bfly_dp`

## Requirements
- R1: With op code 0 (forward butterfly), res_a = (a + w·b) mod q and res_b = (a − w·b) mod q.
- R2: With op code 1 (inverse butterfly), res_a = (a + b) mod q and res_b = ((a − b)·w) mod q.
- R3: With op code 2 (inverse scaling), res_a = (a·w) mod q, where w carries the inverse of the transform length, and res_b equals b unchanged. Only lane a is scaled.
- R4: With op code 3 (bypass), res_a equals a and res_b equals b.
- R5: A transfer sampled at one rising clock edge appears at the outputs MUL_LAT+1 rising edges later, whatever its op code. res_vld is in_vld delayed by exactly that amount.
- R6: The op code and modulus are captured with each transfer. Changing both on every cycle gives each transfer the result of its own code and modulus.
- R7: Results are correct for moduli up to 2^64 − 1, including sums of two operands that exceed 2^64.
- R8: While rst_n is low, res_vld is 0 and res_a and res_b are 0.
- R9: In a cycle where res_vld is low, res_a and res_b hold the values of the most recent valid result (0 if none since reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Transfer strobe for the operand inputs |
| op | input | 2 | Operation: 0 forward, 1 inverse, 2 scale, 3 bypass |
| a | input | W | First coefficient, below q |
| b | input | W | Second coefficient, below q |
| w | input | W | Twiddle factor, or inverse length in scale mode, below q |
| q | input | W | Modulus for this transfer |
| res_vld | output | 1 | Result strobe |
| res_a | output | W | First result coefficient |
| res_b | output | W | Second result coefficient |

## Verification
The hardest case to reach is a modulus close to 2^64 with both operands near q − 1, so that the sum carries out of 64 bits. The same situation also arises with the op code and modulus changing on every consecutive cycle, so that all three multipliers and the bypass path hold data in flight at once. The stimulus covers this with a dedicated phase that uses moduli just below 2^64 and operands pinned to q − 1, q − 2 and 0. A mixed phase draws the op code, the modulus (from small, mid-size and near-2^64 values) and in_vld afresh on every cycle. A reference model in the bench compares each output cycle, including the hold value during gaps.

// File: rtl/ntt_dp_pkg.sv
package ntt_dp_pkg;

   typedef enum logic [1:0] {
      OP_FWD = 2'd0,
      OP_INV = 2'd1,
      OP_SCL = 2'd2,
      OP_BYP = 2'd3
   } bfly_op_e;

   localparam int unsigned MAX_WORD = 64;
   localparam int unsigned MAX_MUL_LAT = 16;

endpackage

// File: rtl/mod_addsub.sv
module mod_addsub #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] q,
   output logic [W-1:0] sum,
   output logic [W-1:0] dif
);

   localparam int unsigned WX = W + 1;

   logic [WX-1:0] raw_sum;
   logic [WX-1:0] red_sum;
   logic [W-1:0]  raw_dif;

   always_comb begin
      raw_sum = {1'b0, x} + {1'b0, y};
      red_sum = raw_sum - {1'b0, q};
      sum     = (raw_sum >= {1'b0, q}) ? red_sum[W-1:0] : raw_sum[W-1:0];
      raw_dif = x - y;
      dif     = (x >= y) ? raw_dif : raw_dif + q;
   end

   always_comb begin
      if ((x < q) && (y < q)) begin
         AST_SUM_REDUCED: assert (sum < q); // R7
         AST_DIF_REDUCED: assert (dif < q); // R7
      end
   end

endmodule

// File: rtl/mod_mul_pipe.sv
module mod_mul_pipe #(
   parameter int unsigned W   = 64,
   parameter int unsigned LAT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] q,
   output logic         out_vld,
   output logic [W-1:0] p
);

   localparam int unsigned WP = 2 * W;

   if (LAT < 1) begin : g_bad_lat
      $error("mod_mul_pipe: LAT must be at least 1");
   end

   logic [WP-1:0] prod_full;
   logic [W-1:0]  prod_red;

   always_comb begin
      prod_full = WP'(x) * WP'(y);
      if (q == '0) prod_red = '0;
      else         prod_red = W'(prod_full % WP'(q));
   end

   logic [LAT-1:0] vpipe;
   logic [W-1:0]   dpipe [LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpipe    <= '0;
         dpipe[0] <= '0;
      end else begin
         vpipe[0] <= in_vld;
         if (in_vld) dpipe[0] <= prod_red;
      end
   end

   for (genvar s = 1; s < LAT; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpipe[s] <= 1'b0;
            dpipe[s] <= '0;
         end else begin
            vpipe[s] <= vpipe[s-1];
            if (vpipe[s-1]) dpipe[s] <= dpipe[s-1];
         end
      end
   end

   assign out_vld = vpipe[LAT-1];
   assign p       = dpipe[LAT-1];

   AST_MUL_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vpipe[LAT-1] |-> $stable(dpipe[LAT-1])); // R6

endmodule

// File: rtl/pipe_delay.sv
module pipe_delay #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout
);

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [DW-1:0] sr [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr[0] <= '0;
         else        sr[0] <= din;
      end
      for (genvar s = 1; s < DEPTH; s++) begin : g_tap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[s] <= '0;
            else        sr[s] <= sr[s-1];
         end
      end
      assign dout = sr[DEPTH-1];
   end

endmodule

// File: rtl/ntt_bfly_dp.sv
module ntt_bfly_dp
   import ntt_dp_pkg::*;
#(
   parameter int unsigned W       = 64,
   parameter int unsigned MUL_LAT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] w,
   input  logic [W-1:0] q,
   output logic         res_vld,
   output logic [W-1:0] res_a,
   output logic [W-1:0] res_b
);

   localparam int unsigned SIDE_W = 1 + 2 + 3 * W;

   if (W < 2 || W > MAX_WORD) begin : g_bad_w
      $error("ntt_bfly_dp: W out of range");
   end
   if (MUL_LAT < 1 || MUL_LAT > MAX_MUL_LAT) begin : g_bad_lat
      $error("ntt_bfly_dp: MUL_LAT out of range");
   end

   // ---------------- input capture ----------------
   logic         v0;
   bfly_op_e     op0;
   logic [W-1:0] a0, b0, w0, q0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v0  <= 1'b0;
         op0 <= OP_FWD;
         a0  <= '0;
         b0  <= '0;
         w0  <= '0;
         q0  <= '0;
      end else begin
         v0 <= in_vld;
         if (in_vld) begin
            op0 <= bfly_op_e'(op);
            a0  <= a;
            b0  <= b;
            w0  <= w;
            q0  <= q;
         end
      end
   end

   // ---------------- inverse butterfly front add/sub ----------------
   logic [W-1:0] gs_sum, gs_dif;

   mod_addsub #(.W(W)) u_gs_pre (
      .x(a0), .y(b0), .q(q0), .sum(gs_sum), .dif(gs_dif)
   );

   // ---------------- three dedicated multipliers ----------------
   logic         ct_go, gs_go, sc_go;
   logic         ct_ov, gs_ov, sc_ov;
   logic [W-1:0] ct_p, gs_p, sc_p;

   assign ct_go = v0 && (op0 == OP_FWD);
   assign gs_go = v0 && (op0 == OP_INV);
   assign sc_go = v0 && (op0 == OP_SCL);

   mod_mul_pipe #(.W(W), .LAT(MUL_LAT)) u_mul_ct (
      .clk(clk), .rst_n(rst_n), .in_vld(ct_go),
      .x(b0), .y(w0), .q(q0), .out_vld(ct_ov), .p(ct_p)
   );

   mod_mul_pipe #(.W(W), .LAT(MUL_LAT)) u_mul_gs (
      .clk(clk), .rst_n(rst_n), .in_vld(gs_go),
      .x(gs_dif), .y(w0), .q(q0), .out_vld(gs_ov), .p(gs_p)
   );

   mod_mul_pipe #(.W(W), .LAT(MUL_LAT)) u_mul_sc (
      .clk(clk), .rst_n(rst_n), .in_vld(sc_go),
      .x(a0), .y(w0), .q(q0), .out_vld(sc_ov), .p(sc_p)
   );

   // ---------------- side lane, aligned to multiplier latency ----------------
   logic [W-1:0]      side_a;
   logic [SIDE_W-1:0] side_in, side_out;

   assign side_a  = (op0 == OP_INV) ? gs_sum : a0;
   assign side_in = {v0, op0, side_a, b0, q0};

   pipe_delay #(.DW(SIDE_W), .DEPTH(MUL_LAT)) u_side (
      .clk(clk), .rst_n(rst_n), .din(side_in), .dout(side_out)
   );

   logic         d_vld;
   bfly_op_e     d_op;
   logic [W-1:0] d_a, d_b, d_q;

   assign d_vld = side_out[SIDE_W-1];
   assign d_op  = bfly_op_e'(side_out[SIDE_W-2 -: 2]);
   assign d_a   = side_out[3*W-1 -: W];
   assign d_b   = side_out[2*W-1 -: W];
   assign d_q   = side_out[W-1:0];

   // ---------------- forward butterfly back add/sub ----------------
   logic [W-1:0] ct_sum, ct_dif;

   mod_addsub #(.W(W)) u_ct_post (
      .x(d_a), .y(ct_p), .q(d_q), .sum(ct_sum), .dif(ct_dif)
   );

   // ---------------- output routing ----------------
   logic [W-1:0] nx_a, nx_b;

   always_comb begin
      unique case (d_op)
         OP_FWD:  begin nx_a = ct_sum; nx_b = ct_dif; end
         OP_INV:  begin nx_a = d_a;    nx_b = gs_p;   end
         OP_SCL:  begin nx_a = sc_p;   nx_b = d_b;    end
         default: begin nx_a = d_a;    nx_b = d_b;    end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res_a   <= '0;
         res_b   <= '0;
      end else begin
         res_vld <= d_vld;
         if (d_vld) begin
            res_a <= nx_a;
            res_b <= nx_b;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_MUL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ct_ov, gs_ov, sc_ov})); // R6

   AST_MUL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (ct_ov || gs_ov || sc_ov) |-> d_vld); // R5

   AST_MUL_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      d_vld |-> (ct_ov == (d_op == OP_FWD)) && (gs_ov == (d_op == OP_INV))
                && (sc_ov == (d_op == OP_SCL))); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> $stable(res_a) && $stable(res_b)); // R9

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      d_vld |=> res_vld); // R5

endmodule

// File: tb/sim_ntt_bfly_dp.sv
module sim_ntt_bfly_dp;

   localparam int unsigned W       = 64;
   localparam int unsigned MUL_LAT = 4;
   localparam int unsigned QDEPTH  = MUL_LAT + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_vld = 1'b0;
   logic [1:0]   op = 2'd0;
   logic [W-1:0] a = '0, b = '0, w = '0, q = '0;
   logic         res_vld;
   logic [W-1:0] res_a, res_b;

   always #2.5 clk = ~clk;

   ntt_bfly_dp #(.W(W), .MUL_LAT(MUL_LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
      .a(a), .b(b), .w(w), .q(q),
      .res_vld(res_vld), .res_a(res_a), .res_b(res_b)
   );

   int n_chk  = 0;
   int n_fail = 0;

   bit           ev_q[$];
   logic [W-1:0] e0_q[$];
   logic [W-1:0] e1_q[$];
   string        tag_q[$];

   logic [W-1:0] last0 = '0, last1 = '0;
   string        phase_tag = "";

   function automatic logic [W-1:0] m_mul(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m);
      logic [2*W-1:0] pr;
      pr = {{W{1'b0}}, x} * {{W{1'b0}}, y};
      return W'(pr % {{W{1'b0}}, m});
   endfunction

   function automatic logic [W-1:0] m_add(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m);
      logic [W:0] s;
      s = {1'b0, x} + {1'b0, y};
      if (s >= {1'b0, m}) s = s - {1'b0, m};
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] m_sub(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] m);
      logic [W:0] s;
      s = {1'b0, x} + {1'b0, m} - {1'b0, y};
      if (s >= {1'b0, m}) s = s - {1'b0, m};
      return s[W-1:0];
   endfunction

   function automatic logic [W-1:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(bit v, logic [1:0] o, logic [W-1:0] xa, logic [W-1:0] xb,
                       logic [W-1:0] xw, logic [W-1:0] xq);
      logic [W-1:0] ex0, ex1;
      string t;
      @(negedge clk);
      in_vld = v; op = o; a = xa; b = xb; w = xw; q = xq;
      case (o)
         2'd0: begin
            ex0 = m_add(xa, m_mul(xw, xb, xq), xq);
            ex1 = m_sub(xa, m_mul(xw, xb, xq), xq);
            t = "R1";
         end
         2'd1: begin
            ex0 = m_add(xa, xb, xq);
            ex1 = m_mul(m_sub(xa, xb, xq), xw, xq);
            t = "R2";
         end
         2'd2: begin
            ex0 = m_mul(xa, xw, xq);
            ex1 = xb;
            t = "R3";
         end
         default: begin
            ex0 = xa;
            ex1 = xb;
            t = "R4";
         end
      endcase
      @(posedge clk);
      #1;
      ev_q.push_back(v);
      e0_q.push_back(ex0);
      e1_q.push_back(ex1);
      tag_q.push_back({t, " ", phase_tag});
      if (ev_q.size() == QDEPTH) begin
         bit           pv;
         logic [W-1:0] p0, p1;
         string        pt;
         pv = ev_q.pop_front();
         p0 = e0_q.pop_front();
         p1 = e1_q.pop_front();
         pt = tag_q.pop_front();
         check("R5 res_vld", {{(W-1){1'b0}}, res_vld}, {{(W-1){1'b0}}, pv});
         if (pv) begin
            check({pt, " res_a"}, res_a, p0);
            check({pt, " res_b"}, res_b, p1);
            last0 = p0;
            last1 = p1;
         end else begin
            check("R9 hold res_a", res_a, last0);
            check("R9 hold res_b", res_b, last1);
         end
      end
   endtask

   task automatic rnd_step(logic [W-1:0] m, bit v, logic [1:0] o);
      step(v, o, rnd64() % m, rnd64() % m, rnd64() % m, m);
   endtask

   logic [W-1:0] qset [6];

   initial begin
      qset[0] = 64'd17;
      qset[1] = 64'd12289;
      qset[2] = 64'h0000_0000_FFFF_FFFB;
      qset[3] = 64'h0FFF_FFFF_0000_0001;
      qset[4] = 64'hFFFF_FFFF_0000_0001;
      qset[5] = 64'hFFFF_FFFF_FFFF_FFC5;

      // R8: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R8 res_vld", {{(W-1){1'b0}}, res_vld}, '0);
      check("R8 res_a", res_a, '0);
      check("R8 res_b", res_b, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed, small modulus
      phase_tag = "directed";
      step(1'b1, 2'd0, 64'd3, 64'd5, 64'd4, 64'd17);
      step(1'b1, 2'd1, 64'd3, 64'd5, 64'd4, 64'd17);
      step(1'b1, 2'd2, 64'd9, 64'd7, 64'd16, 64'd17);
      step(1'b1, 2'd3, 64'd11, 64'd2, 64'd1, 64'd17);
      step(1'b1, 2'd0, 64'd0, 64'd0, 64'd0, 64'd17);
      step(1'b1, 2'd1, 64'd6, 64'd6, 64'd5, 64'd17);
      repeat (QDEPTH) step(1'b0, 2'd0, '0, '0, '0, 64'd17);

      // one mode at a time, random operands, all moduli
      for (int md = 0; md < 4; md++) begin
         phase_tag = "per-mode";
         for (int k = 0; k < 300; k++)
            rnd_step(qset[k % 6], 1'b1, 2'(md));
      end

      // R7: carries beyond 64 bits, operands at q-1, q-2, 0
      phase_tag = "R7";
      for (int k = 0; k < 200; k++) begin
         logic [W-1:0] m, xa, xb, xw;
         m  = (k % 2 == 0) ? qset[5] : qset[4];
         xa = (k % 3 == 0) ? m - 1 : ((k % 3 == 1) ? m - 2 : '0);
         xb = (k % 5 == 0) ? '0 : m - 1;
         xw = (k % 7 == 0) ? m - 1 : rnd64() % m;
         step(1'b1, 2'(k % 4), xa, xb, xw, m);
      end

      // R6: op code, modulus and valid change every cycle
      phase_tag = "R6";
      for (int k = 0; k < 4000; k++)
         rnd_step(qset[$urandom % 6], ($urandom % 4) != 0, 2'($urandom % 4));

      // R9: long gap then check hold
      phase_tag = "R9";
      repeat (2 * QDEPTH) step(1'b0, 2'd1, rnd64(), rnd64(), rnd64(), 64'd17);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule